// File: doc/BRIEF.md
# Source Burst Scheduler with Write-Pattern Checker

This block sits between a user write port that loads a source FIFO and the 16-bit transmit word stream of a packet source interface. Every user write is inspected for illegal patterns, and an illegal write raises a one-cycle error pulse. Every write is still stored: the check only reports.

On the transmit side, the block chooses at each burst boundary what to send next. A training request wins over an idle request, and an idle request wins over packet data. A data burst is a payload control word followed by up to eight data words. A training sequence is 21 words long and is always sent in full. When nothing else applies, idle control words fill the stream. Requests that arrive in the middle of a burst or a training sequence wait for its end. A separate registered flag tells the pad drivers to float the transmit outputs.

Top module: `burst_src_sched`

## Requirements
- R1: A write with `wr_mod` non-zero while `wr_eop` is 0 is illegal.
- R2: A write with `wr_sop`=1 is illegal when the previous packet is still open (no `wr_eop` seen) and the number of words written since its start is not a multiple of 8. After exactly 8 words, the same write is legal.
- R3: `pat_err` is 1 in the cycle after each illegal write and 0 after legal writes or no write. A lone illegal write gives a pulse of exactly one cycle.
- R4: A data burst is a control word with `tx_ctl`=1 and value 16'h8000, with bit 12 set when the first data word carries start-of-packet. It is followed by data words with `tx_ctl`=0. The burst ends after 8 data words or at the word that carries end-of-packet, whichever comes first. The next boundary decision follows with no gap.
- R5: A burst starts only when the FIFO holds at least 8 words or at least one end-of-packet word. Otherwise the block sends the idle word 16'h000F with `tx_ctl`=1.
- R6: While `idle_req` is 1, each boundary produces one idle word, and no data burst starts.
- R7: A training sequence is one idle word, then 10 words 16'h0FFF with `tx_ctl`=1, then 10 words 16'hF000 with `tx_ctl`=0. Once started, all 21 words are sent even if `train_req` falls.
- R8: A request raised during a data burst takes effect only after the last data word of that burst.
- R9: Priority at a boundary is training, then idle, then data. Data waiting in the FIFO stays there through training and idle.
- R10: Requests never alter the FIFO contents or stall writes. Words written while idle is requested are later sent unchanged and in order.
- R11: `tx_hiz` equals `out_dis` delayed by one cycle.
- R12: After reset, `tx_data`=16'h000F, `tx_ctl`=1, `tx_hiz`=0 and `pat_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write side and the transmit side |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe into the source FIFO |
| wr_data | input | 16 | Write data word |
| wr_sop | input | 1 | Word starts a packet |
| wr_eop | input | 1 | Word ends a packet |
| wr_mod | input | 1 | Odd-byte marker, legal only with end-of-packet |
| idle_req | input | 1 | Request idle words at the next boundary |
| train_req | input | 1 | Request a training sequence at the next boundary |
| out_dis | input | 1 | Request high impedance on the transmit pads |
| tx_data | output | 16 | Transmit word |
| tx_ctl | output | 1 | Transmit word is a control word |
| tx_hiz | output | 1 | Float the transmit clock, data and control pads |
| pat_err | output | 1 | One-cycle pulse for an illegal write |

## Verification
The embedded properties check the following on every cycle:
- the error pulse for a non-zero modulo value and that each pulse traces back to a write;
- that the FIFO is never read while empty and that its end-of-packet count stays consistent;
- that a boundary facing a training or idle request emits the idle word and enters the proper state;
- that a running burst or training sequence is never cut short;
- the one-cycle delay of the float flag.

Only the bench scenarios can show the rest:
- the exact word order of bursts built from a stored set of packets;
- the full 21-word training pattern when the request falls midway;
- the deferral of a mid-burst training request;
- that packets written under an idle request come out unchanged.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int WORD_W = 16;
    localparam int MOD_W  = 1;

    localparam logic [WORD_W-1:0] IDLE_CW  = 16'h000F;
    localparam logic [WORD_W-1:0] TRAIN_CW = 16'h0FFF;
    localparam logic [WORD_W-1:0] TRAIN_DW = 16'hF000;
    localparam logic [WORD_W-1:0] PCW_BASE = 16'h8000;

    typedef struct packed {
        logic              sop;
        logic              eop;
        logic [WORD_W-1:0] data;
    } fifo_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              ctl;
    } tx_word_t;

    typedef enum logic [1:0] {
        ST_BND   = 2'd0,
        ST_DATA  = 2'd1,
        ST_TRAIN = 2'd2
    } tx_state_t;

    function automatic tx_word_t idle_word();
        tx_word_t w;
        w.data = IDLE_CW;
        w.ctl  = 1'b1;
        return w;
    endfunction

    function automatic tx_word_t payload_cw(input logic first_is_sop);
        tx_word_t w;
        w.data = PCW_BASE | {3'b000, first_is_sop, 12'h000};
        w.ctl  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/bss_pat_check.sv
module bss_pat_check
    import bss_pkg::*;
#(
    parameter int BURST_WORDS = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic [MOD_W-1:0] wr_mod,
    output logic             pat_err
);

    localparam int PW = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;
    localparam logic [PW-1:0] PH_LAST = PW'(BURST_WORDS - 1);

    logic [PW-1:0] phase_q;
    logic          open_q;
    logic          mod_bad;
    logic          cut_bad;
    logic [PW-1:0] phase_base;
    logic [PW-1:0] phase_nxt;

    always_comb begin
        mod_bad    = wr_en && !wr_eop && (wr_mod != '0);
        cut_bad    = wr_en && wr_sop && open_q && (phase_q != '0);
        phase_base = wr_sop ? '0 : phase_q;
        phase_nxt  = (phase_base == PH_LAST) ? '0 : phase_base + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            open_q  <= 1'b0;
            pat_err <= 1'b0;
        end else begin
            pat_err <= mod_bad || cut_bad;
            if (wr_en) begin
                open_q  <= !wr_eop;
                phase_q <= phase_nxt;
            end
        end
    end

    p_mod_err_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_eop && (wr_mod != '0)) |=> pat_err);

    p_err_from_write_r3: assert property (@(posedge clk) disable iff (rst)
        pat_err |-> $past(wr_en));

    p_fresh_packet_ok_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sop && !open_q && (wr_eop || (wr_mod == '0))) |=> !pat_err);

endmodule

// File: rtl/bss_fifo.sv
module bss_fifo
    import bss_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  fifo_word_t      wr_word,
    input  logic            rd_en,
    output fifo_word_t      head,
    output logic [CNTW-1:0] count,
    output logic [CNTW-1:0] eop_cnt
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);

    fifo_word_t    mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          do_wr;
    logic          do_rd;
    logic          eop_in;
    logic          eop_out;

    always_comb begin
        head    = mem[rd_ptr];
        do_wr   = wr_en && (count != FULL_CNT);
        do_rd   = rd_en && (count != '0);
        eop_in  = do_wr && wr_word.eop;
        eop_out = do_rd && head.eop;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            eop_cnt <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
            count   <= count + CNTW'(do_wr) - CNTW'(do_rd);
            eop_cnt <= eop_cnt + CNTW'(eop_in) - CNTW'(eop_out);
        end
    end

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (count != '0));

    p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    p_eop_within_count_r5: assert property (@(posedge clk) disable iff (rst)
        eop_cnt <= count);

endmodule

// File: rtl/bss_tx_seq.sv
module bss_tx_seq
    import bss_pkg::*;
#(
    parameter int BURST_WORDS = 8,
    parameter int TRAIN_REPS  = 10,
    parameter int CNTW        = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              train_req,
    input  logic              idle_req,
    input  logic              out_dis,
    input  fifo_word_t        head,
    input  logic [CNTW-1:0]   count,
    input  logic [CNTW-1:0]   eop_cnt,
    output logic              rd_en,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_ctl,
    output logic              tx_hiz
);

    localparam int TRAIN_LEN = 1 + 2 * TRAIN_REPS;
    localparam int STEP_MAX  = (TRAIN_LEN > BURST_WORDS) ? TRAIN_LEN : BURST_WORDS;
    localparam int SW        = $clog2(STEP_MAX + 1);
    localparam logic [SW-1:0]   TR_LAST = SW'(TRAIN_LEN - 1);
    localparam logic [SW-1:0]   TR_CTL  = SW'(TRAIN_REPS);
    localparam logic [SW-1:0]   BU_LAST = SW'(BURST_WORDS - 1);
    localparam logic [CNTW-1:0] BU_FULL = CNTW'(BURST_WORDS);

    tx_state_t     state_q;
    tx_state_t     state_n;
    logic [SW-1:0] step_q;
    logic [SW-1:0] step_n;
    tx_word_t      word_n;
    logic          burst_ok;

    always_comb begin
        burst_ok = (count >= BU_FULL) || (eop_cnt != '0);
        state_n  = state_q;
        step_n   = step_q;
        word_n   = idle_word();
        rd_en    = 1'b0;
        case (state_q)
            ST_BND: begin
                if (train_req) begin
                    word_n  = idle_word();
                    state_n = ST_TRAIN;
                    step_n  = SW'(1);
                end else if (idle_req) begin
                    word_n  = idle_word();
                end else if (burst_ok) begin
                    word_n  = payload_cw(head.sop);
                    state_n = ST_DATA;
                    step_n  = '0;
                end
            end
            ST_TRAIN: begin
                if (step_q <= TR_CTL) begin
                    word_n.data = TRAIN_CW;
                    word_n.ctl  = 1'b1;
                end else begin
                    word_n.data = TRAIN_DW;
                    word_n.ctl  = 1'b0;
                end
                if (step_q == TR_LAST) begin
                    state_n = ST_BND;
                    step_n  = '0;
                end else begin
                    step_n  = step_q + 1'b1;
                end
            end
            ST_DATA: begin
                rd_en       = 1'b1;
                word_n.data = head.data;
                word_n.ctl  = 1'b0;
                if (head.eop || (step_q == BU_LAST)) begin
                    state_n = ST_BND;
                    step_n  = '0;
                end else begin
                    step_n  = step_q + 1'b1;
                end
            end
            default: begin
                state_n = ST_BND;
                step_n  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BND;
            step_q  <= '0;
            tx_data <= IDLE_CW;
            tx_ctl  <= 1'b1;
            tx_hiz  <= 1'b0;
        end else begin
            state_q <= state_n;
            step_q  <= step_n;
            tx_data <= word_n.data;
            tx_ctl  <= word_n.ctl;
            tx_hiz  <= out_dis;
        end
    end

    p_burst_has_data_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (count != '0));

    p_burst_len_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (step_q <= BU_LAST));

    p_train_first_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BND && train_req) |=>
            (state_q == ST_TRAIN && tx_data == IDLE_CW && tx_ctl));

    p_idle_over_data_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BND && !train_req && idle_req) |=>
            (state_q == ST_BND && tx_data == IDLE_CW && tx_ctl));

    p_train_full_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TRAIN && step_q != TR_LAST) |=> (state_q == ST_TRAIN));

    p_burst_defer_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA && !head.eop && step_q != BU_LAST) |=> (state_q == ST_DATA));

    p_hiz_follow_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tx_hiz == $past(out_dis)));

endmodule

// File: rtl/burst_src_sched.sv
module burst_src_sched
    import bss_pkg::*;
#(
    parameter int FIFO_DEPTH  = 32,
    parameter int BURST_WORDS = 8,
    parameter int TRAIN_REPS  = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_sop,
    input  logic              wr_eop,
    input  logic [MOD_W-1:0]  wr_mod,
    input  logic              idle_req,
    input  logic              train_req,
    input  logic              out_dis,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_ctl,
    output logic              tx_hiz,
    output logic              pat_err
);

    localparam int CNTW = $clog2(FIFO_DEPTH + 1);

    fifo_word_t      wr_word;
    fifo_word_t      head;
    logic [CNTW-1:0] count;
    logic [CNTW-1:0] eop_cnt;
    logic            rd_en;

    always_comb begin
        wr_word.sop  = wr_sop;
        wr_word.eop  = wr_eop;
        wr_word.data = wr_data;
    end

    bss_pat_check #(
        .BURST_WORDS (BURST_WORDS)
    ) u_check (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sop  (wr_sop),
        .wr_eop  (wr_eop),
        .wr_mod  (wr_mod),
        .pat_err (pat_err)
    );

    bss_fifo #(
        .DEPTH (FIFO_DEPTH),
        .CNTW  (CNTW)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .rd_en   (rd_en),
        .head    (head),
        .count   (count),
        .eop_cnt (eop_cnt)
    );

    bss_tx_seq #(
        .BURST_WORDS (BURST_WORDS),
        .TRAIN_REPS  (TRAIN_REPS),
        .CNTW        (CNTW)
    ) u_tx (
        .clk       (clk),
        .rst       (rst),
        .train_req (train_req),
        .idle_req  (idle_req),
        .out_dis   (out_dis),
        .head      (head),
        .count     (count),
        .eop_cnt   (eop_cnt),
        .rd_en     (rd_en),
        .tx_data   (tx_data),
        .tx_ctl    (tx_ctl),
        .tx_hiz    (tx_hiz)
    );

endmodule

// File: tb/burst_src_sched_tb.sv
module burst_src_sched_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_sop = 1'b0;
    logic        wr_eop = 1'b0;
    logic [0:0]  wr_mod = '0;
    logic        idle_req = 1'b0;
    logic        train_req = 1'b0;
    logic        out_dis = 1'b0;
    logic [15:0] tx_data;
    logic        tx_ctl;
    logic        tx_hiz;
    logic        pat_err;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    burst_src_sched u_dut (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_sop    (wr_sop),
        .wr_eop    (wr_eop),
        .wr_mod    (wr_mod),
        .idle_req  (idle_req),
        .train_req (train_req),
        .out_dis   (out_dis),
        .tx_data   (tx_data),
        .tx_ctl    (tx_ctl),
        .tx_hiz    (tx_hiz),
        .pat_err   (pat_err)
    );

    // row: {tag[3:0], exp_err, sop, eop, mod, data[15:0]}
    localparam logic [23:0] VEC [0:15] = '{
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'hA001},
        {4'd1, 1'b1, 1'b0, 1'b0, 1'b1, 16'hA002},
        {4'd3, 1'b0, 1'b0, 1'b1, 1'b1, 16'hA003},
        {4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'hB001},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB002},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hB003},
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'hC001},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC002},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC003},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC004},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC005},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC006},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC007},
        {4'd3, 1'b0, 1'b0, 1'b0, 1'b0, 16'hC008},
        {4'd2, 1'b0, 1'b1, 1'b1, 1'b0, 16'hD001},
        {4'd3, 1'b0, 1'b1, 1'b1, 1'b0, 16'hE001}
    };

    // expected non-idle stream after the idle request falls: {ctl, data}
    localparam logic [16:0] DRAIN [0:19] = '{
        {1'b1, 16'h9000}, {1'b0, 16'hA001}, {1'b0, 16'hA002}, {1'b0, 16'hA003},
        {1'b1, 16'h9000}, {1'b0, 16'hB001}, {1'b0, 16'hB002}, {1'b0, 16'hB003},
        {1'b0, 16'hC001}, {1'b0, 16'hC002}, {1'b0, 16'hC003}, {1'b0, 16'hC004},
        {1'b0, 16'hC005}, {1'b1, 16'h8000}, {1'b0, 16'hC006}, {1'b0, 16'hC007},
        {1'b0, 16'hC008}, {1'b0, 16'hD001}, {1'b1, 16'h9000}, {1'b0, 16'hE001}
    };

    localparam logic [16:0] W_IDLE = {1'b1, 16'h000F};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [16:0] txw();
        return {tx_ctl, tx_data};
    endfunction

    function automatic logic [16:0] train_exp(input int s);
        if (s == 0)      return W_IDLE;
        else if (s <= 10) return {1'b1, 16'h0FFF};
        else             return {1'b0, 16'hF000};
    endfunction

    task automatic put(input logic sop, input logic eop, input logic [15:0] d);
        wr_en = 1'b1; wr_sop = sop; wr_eop = eop; wr_mod = 1'b0; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [16:0] got [0:39];
        int ngot;
        int bad;
        bit seen;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(txw() == W_IDLE, "R12 tx word", 32'(txw()), 32'(W_IDLE));
        chk(!tx_hiz, "R12 tx_hiz", 32'(tx_hiz), 0);
        chk(!pat_err, "R12 pat_err", 32'(pat_err), 0);

        // table walk with idle requested: pattern checks R1 R2 R3
        idle_req = 1'b1;
        bad = 0;
        for (int i = 0; i < 16; i++) begin
            wr_en = 1'b1;
            wr_sop = VEC[i][18];
            wr_eop = VEC[i][17];
            wr_mod = VEC[i][16];
            wr_data = VEC[i][15:0];
            @(negedge clk);
            case (VEC[i][23:20])
                4'd1: chk(pat_err == VEC[i][19], "R1 mod without eop", 32'(pat_err), 32'(VEC[i][19]));
                4'd2: chk(pat_err == VEC[i][19], "R2 burst cut", 32'(pat_err), 32'(VEC[i][19]));
                default: chk(pat_err == VEC[i][19], "R3 legal write", 32'(pat_err), 32'(VEC[i][19]));
            endcase
            if (txw() != W_IDLE) bad++;
        end
        wr_en = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_mod = 1'b0;
        @(negedge clk);
        chk(!pat_err, "R3 pulse ends", 32'(pat_err), 0);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (txw() != W_IDLE) bad++;
        end
        chk(bad == 0, "R6 only idle under idle request", bad, 0);

        // drain: R4 R5 R10
        idle_req = 1'b0;
        ngot = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txw() != W_IDLE && ngot < 40) begin
                got[ngot] = txw();
                ngot++;
            end
        end
        chk(ngot == 20, "R10 drained word count", ngot, 20);
        for (int i = 0; i < 20; i++)
            chk(got[i] == DRAIN[i], "R4 R10 burst stream", 32'(got[i]), 32'(DRAIN[i]));

        // R5: partial packet, no burst yet
        put(1'b1, 1'b0, 16'h5001);
        put(1'b0, 1'b0, 16'h5002);
        put(1'b0, 1'b0, 16'h5003);
        bad = 0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (txw() != W_IDLE) bad++;
        end
        chk(bad == 0, "R5 idle while less than a burst", bad, 0);
        for (int i = 4; i <= 8; i++)
            put(1'b0, i == 8, 16'h5000 + 16'(i));

        // R8: training raised mid-burst waits; R7 full pattern
        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            @(negedge clk);
            if (txw() == {1'b1, 16'h9000}) seen = 1'b1;
        end
        chk(seen, "R5 burst starts at eight words", 32'(seen), 1);
        train_req = 1'b1;
        for (int s = 0; s < 30; s++) begin
            @(negedge clk);
            if (s < 8)
                chk(txw() == {1'b0, 16'h5001 + 16'(s)}, "R8 burst finishes first",
                    32'(txw()), 32'({1'b0, 16'h5001 + 16'(s)}));
            else if (s < 29)
                chk(txw() == train_exp(s - 8), "R7 training pattern",
                    32'(txw()), 32'(train_exp(s - 8)));
            else
                chk(txw() == W_IDLE, "R7 idle after training", 32'(txw()), 32'(W_IDLE));
            if (s == 9) train_req = 1'b0;
        end

        // R9: training over idle over data
        train_req = 1'b1;
        idle_req = 1'b1;
        put(1'b1, 1'b1, 16'h6001);
        chk(txw() == W_IDLE, "R9 training lead word", 32'(txw()), 32'(W_IDLE));
        @(negedge clk);
        chk(txw() == {1'b1, 16'h0FFF}, "R9 training wins", 32'(txw()), 32'({1'b1, 16'h0FFF}));
        train_req = 1'b0;
        repeat (19) @(negedge clk);
        chk(txw() == {1'b0, 16'hF000}, "R7 last training word", 32'(txw()), 32'({1'b0, 16'hF000}));
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (txw() != W_IDLE) bad++;
        end
        chk(bad == 0, "R9 idle wins over data", bad, 0);
        idle_req = 1'b0;
        @(negedge clk);
        chk(txw() == {1'b1, 16'h9000}, "R9 data after idle", 32'(txw()), 32'({1'b1, 16'h9000}));
        @(negedge clk);
        chk(txw() == {1'b0, 16'h6001}, "R10 kept word", 32'(txw()), 32'({1'b0, 16'h6001}));
        @(negedge clk);
        chk(txw() == W_IDLE, "R5 idle when empty", 32'(txw()), 32'(W_IDLE));

        // R11 output disable
        out_dis = 1'b1;
        @(negedge clk);
        chk(tx_hiz, "R11 hiz on", 32'(tx_hiz), 1);
        out_dis = 1'b0;
        @(negedge clk);
        chk(!tx_hiz, "R11 hiz off", 32'(tx_hiz), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule